// File: doc/BRIEF.md
# Multiplexed Code Fetch Bus Sequencer

This block gets one instruction byte for an 8-bit controller core each time the core asks for it. A 16-bit program counter names the byte. A strap input picks where the byte comes from. When the strap is high, the byte comes from an on-chip code ROM model. When the strap is low, the block runs a cycle on an external bus. On that bus, the low address byte and the returned code byte share one 8-bit port. The upper address byte has a port of its own and is driven directly.

An external cycle has fixed phases:

1. The address strobe is high while the shared port drives the counter's low byte.
2. The strobe falls and the port keeps the address for one state.
3. The port stops driving for one state.
4. An active-low read strobe is asserted for a parameterised number of states.
5. The port is sampled in the last read state.

The core receives the byte together with a one-cycle valid pulse. The counter then steps by one. A new fetch begins only after that pulse, and only while the core's request is high.

Top module: `code_fetch_bus`

## Requirements
- R1: While reset is held and right after it, pc_o is 0000h, ale_o is 0, ad_oe_o is 0, code_rd_no is 1 and byte_vld_o is 0. The first fetch uses address 0000h.
- R2: A fetch that starts with int_code_i=1 drives no bus activity: ale_o stays 0, ad_oe_o stays 0 and code_rd_no stays 1. It returns the internal ROM byte {a[3:0],a[7:4]} ^ a[15:8] ^ A5h for address a.
- R3: A fetch that starts with int_code_i=0 raises ale_o for exactly one cycle. During that cycle ad_oe_o=1 and ad_o equals pc_o[7:0]. In the following cycle ale_o is 0 and ad_oe_o is still 1.
- R4: addr_hi_o equals pc_o[15:8] in every cycle of every fetch.
- R5: ad_oe_o and an active code_rd_no never coincide. At least one cycle with ad_oe_o=0 separates the last driven cycle from the first read-strobe cycle.
- R6: In an external fetch, code_rd_no is low for RD_CYC consecutive cycles (default 2). byte_vld_o rises in the cycle right after the last read cycle, carrying the ad_i value of that last read cycle.
- R7: byte_vld_o is a single-cycle pulse. pc_o rises by one in the cycle after each pulse, carries from 00FFh to 0100h, and is unchanged otherwise.
- R8: With fetch_req_i low and no fetch in flight, no bus activity occurs and no byte is delivered. A request dropped in the valid cycle starts no further fetch.
- R9: int_code_i is sampled only when a fetch starts. Changing it while a fetch is in flight does not alter that fetch; the next fetch follows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Core asks for the next code byte |
| int_code_i | input | 1 | Strap: 1 = internal ROM, 0 = external bus |
| byte_o | output | 8 | Fetched code byte |
| byte_vld_o | output | 1 | One-cycle pulse, byte_o valid |
| pc_o | output | 16 | Program counter |
| ale_o | output | 1 | Address latch strobe for the external latch |
| ad_o | output | 8 | Shared port, outgoing value (low address byte) |
| ad_oe_o | output | 1 | Shared port drive enable |
| ad_i | input | 8 | Shared port, incoming value (code byte) |
| addr_hi_o | output | 8 | Upper address byte |
| code_rd_no | output | 1 | Code read strobe, active low |

## Verification
Two events can fall in the same cycle: a change of the strap and a fetch already in flight. The bench flips int_code_i during the float phase of an external fetch. It then checks that this fetch still completes its bus phases and returns the external byte, and that only the following fetch switches to the internal ROM. A second collision is a request that drops in the very cycle the valid pulse appears. The bench checks that no address strobe, read strobe or further pulse follows and that pc_o stays put.

// File: rtl/code_fetch_pkg.sv
package code_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_FLOAT = 3'd3,
    ST_READ  = 3'd4,
    ST_IRD   = 3'd5,
    ST_DONE  = 3'd6
  } fetch_st_e;

endpackage

// File: rtl/code_fetch_pc.sv
module code_fetch_pc #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  output logic [PC_W-1:0] pc_o
);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (inc_i) pc_q <= pc_q + PC_W'(1);
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/code_fetch_rom.sv
// Internal code store model: content computed from the address, no storage.
module code_fetch_rom #(
  parameter int unsigned   PC_W = 16,
  parameter int unsigned   DW   = 8,
  parameter logic [DW-1:0] KEY  = 8'hA5
) (
  input  logic [PC_W-1:0] addr_i,
  output logic [DW-1:0]   data_o
);

  localparam int unsigned HI_W = PC_W - DW;
  localparam int unsigned HALF = DW / 2;

  logic [DW-1:0] lo_swap;
  logic [DW-1:0] hi_fold;

  assign lo_swap = {addr_i[HALF-1:0], addr_i[DW-1:HALF]};

  always_comb begin
    hi_fold = '0;
    for (int i = 0; i < int'(HI_W); i++) begin
      hi_fold[i % DW] = hi_fold[i % DW] ^ addr_i[DW+i];
    end
  end

  assign data_o = lo_swap ^ hi_fold ^ KEY;

endmodule

// File: rtl/code_fetch_seq.sv
module code_fetch_seq
  import code_fetch_pkg::*;
#(
  parameter int unsigned RD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic int_code_i,
  output logic ale_o,
  output logic oe_o,
  output logic rd_no,
  output logic cap_ext_o,
  output logic cap_int_o,
  output logic done_o
);

  localparam int unsigned CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;

  fetch_st_e     state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          last_rd;

  assign last_rd = (state_q == ST_READ) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = int_code_i ? ST_IRD : ST_ADDR;
      ST_ADDR:  state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_FLOAT;
      ST_FLOAT: state_d = ST_READ;
      ST_READ:  if (last_rd) state_d = ST_DONE;
      ST_IRD:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FLOAT)                     cnt_q <= CW'(RD_CYC - 1);
      else if (state_q == ST_READ && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  assign ale_o     = (state_q == ST_ADDR);
  assign oe_o      = (state_q == ST_ADDR) || (state_q == ST_HOLD);
  assign rd_no     = (state_q != ST_READ);
  assign cap_ext_o = last_rd;
  assign cap_int_o = (state_q == ST_IRD);
  assign done_o    = (state_q == ST_DONE);

endmodule

// File: rtl/code_fetch_bus.sv
module code_fetch_bus #(
  parameter int unsigned   PC_W    = 16,
  parameter int unsigned   DW      = 8,
  parameter int unsigned   RD_CYC  = 2,
  parameter logic [DW-1:0] ROM_KEY = 8'hA5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fetch_req_i,
  input  logic                 int_code_i,
  output logic [DW-1:0]        byte_o,
  output logic                 byte_vld_o,
  output logic [PC_W-1:0]      pc_o,
  output logic                 ale_o,
  output logic [DW-1:0]        ad_o,
  output logic                 ad_oe_o,
  input  logic [DW-1:0]        ad_i,
  output logic [PC_W-DW-1:0]   addr_hi_o,
  output logic                 code_rd_no
);

  localparam int unsigned HI_W = PC_W - DW;

  logic [PC_W-1:0] pc;
  logic [DW-1:0]   rom_data;
  logic [DW-1:0]   byte_q;
  logic            cap_ext, cap_int, done, oe;

  code_fetch_seq #(.RD_CYC(RD_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (fetch_req_i),
    .int_code_i (int_code_i),
    .ale_o      (ale_o),
    .oe_o       (oe),
    .rd_no      (code_rd_no),
    .cap_ext_o  (cap_ext),
    .cap_int_o  (cap_int),
    .done_o     (done)
  );

  code_fetch_pc #(.PC_W(PC_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (done),
    .pc_o   (pc)
  );

  code_fetch_rom #(.PC_W(PC_W), .DW(DW), .KEY(ROM_KEY)) u_rom (
    .addr_i (pc),
    .data_o (rom_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      byte_q <= '0;
    else if (cap_ext) byte_q <= ad_i;
    else if (cap_int) byte_q <= rom_data;
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = done;
  assign pc_o       = pc;
  assign ad_oe_o    = oe;
  assign ad_o       = oe ? pc[DW-1:0] : '0;
  assign addr_hi_o  = pc[PC_W-1:PC_W-HI_W];

endmodule

// File: rtl/code_fetch_bus_chk.sv
module code_fetch_bus_chk #(
  parameter int unsigned PC_W = 16,
  parameter int unsigned DW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ale_o,
  input logic [DW-1:0]   ad_o,
  input logic            ad_oe_o,
  input logic            code_rd_no,
  input logic            byte_vld_o,
  input logic [PC_W-1:0] pc_o
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!ale_o && !ad_oe_o && code_rd_no && !byte_vld_o && pc_o == '0); // R1
    end
  end

  AST_ALE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && ad_o == pc_o[DW-1:0])); // R3

  AST_ALE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && ad_oe_o)); // R3

  AST_PORT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ad_oe_o && !code_rd_no)); // R5

  AST_FLOAT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(code_rd_no) |-> !$past(ad_oe_o)); // R5

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o); // R7

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> (pc_o == $past(pc_o) + PC_W'(1))); // R7

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |=> $stable(pc_o)); // R7

endmodule

bind code_fetch_bus code_fetch_bus_chk #(.PC_W(PC_W), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ale_o      (ale_o),
  .ad_o       (ad_o),
  .ad_oe_o    (ad_oe_o),
  .code_rd_no (code_rd_no),
  .byte_vld_o (byte_vld_o),
  .pc_o       (pc_o)
);

// File: tb/sim_code_fetch_bus.sv
module sim_code_fetch_bus;

  localparam int CLK_PER = 10;
  localparam int RD_CYC  = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic        int_code_i = 1'b1;
  logic [7:0]  byte_o;
  logic        byte_vld_o;
  logic [15:0] pc_o;
  logic        ale_o;
  logic [7:0]  ad_o;
  logic        ad_oe_o;
  logic [7:0]  ad_i;
  logic [7:0]  addr_hi_o;
  logic        code_rd_no;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_pc = 16'h0000;
  logic [7:0]  lat_q = 8'h00;

  always #(CLK_PER/2) clk_i = ~clk_i;

  code_fetch_bus u0 (
    .clk_i, .rst_ni, .fetch_req_i, .int_code_i, .byte_o, .byte_vld_o, .pc_o,
    .ale_o, .ad_o, .ad_oe_o, .ad_i, .addr_hi_o, .code_rd_no
  );

  function automatic logic [7:0] rom_ref(input logic [15:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ext_ref(input logic [15:0] a);
    return (a[7:0] + 8'd17) ^ {a[14:8], a[15]};
  endfunction

  // external address latch and code memory
  always @(negedge clk_i) if (ale_o) lat_q <= ad_o;
  always_comb ad_i = code_rd_no ? 8'hEE : ext_ref({addr_hi_o, lat_q});

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one fetch; flip toggles the strap during the float phase
  task automatic fetch_one(input bit ext, input bit flip, input bit drop_in_vld);
    int ale_n = 0, oe_n = 0, rd_n = 0, last_oe = -1, first_rd = -1, last_rd = -1;
    int vld_k = -1;
    bit hi_bad = 0, lo_bad = 0;
    logic [7:0] got = 8'h00;
    logic [7:0] exp_b;
    @(negedge clk_i);
    fetch_req_i = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk_i);
      if (addr_hi_o != exp_pc[15:8]) hi_bad = 1;
      if (ale_o) begin ale_n++; if (ad_o != exp_pc[7:0]) lo_bad = 1; end
      if (ad_oe_o) begin oe_n++; last_oe = k; end
      if (!code_rd_no) begin rd_n++; if (first_rd < 0) first_rd = k; last_rd = k; end
      if (flip && k == 3) int_code_i = ~int_code_i;
      if (byte_vld_o) begin
        vld_k = k; got = byte_o;
        if (drop_in_vld) fetch_req_i = 1'b0;
        break;
      end
    end
    if (!drop_in_vld) fetch_req_i = 1'b0;
    exp_b = ext ? ext_ref(exp_pc) : rom_ref(exp_pc);
    chk(vld_k > 0, "R7", "valid pulse seen", vld_k, 1);
    chk(!hi_bad, "R4", "upper address port", addr_hi_o, exp_pc[15:8]);
    if (ext) begin
      chk(got == exp_b, "R6", "external byte", got, exp_b);
      chk(ale_n == 1 && !lo_bad, "R3", "address strobe count/low byte", ale_n, 1);
      chk(rd_n == RD_CYC, "R6", "read strobe length", rd_n, RD_CYC);
      chk(first_rd - last_oe >= 2, "R5", "float gap", first_rd - last_oe, 2);
      chk(vld_k == last_rd + 1, "R6", "valid after last read", vld_k, last_rd + 1);
    end else begin
      chk(got == exp_b, "R2", "internal byte", got, exp_b);
      chk(ale_n == 0 && oe_n == 0 && rd_n == 0, "R2", "no bus activity",
          ale_n + oe_n + rd_n, 0);
    end
    exp_pc = exp_pc + 16'd1;
    @(negedge clk_i);
    chk(pc_o == exp_pc, "R7", "pc step", pc_o, exp_pc);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!ale_o && !ad_oe_o && code_rd_no && !byte_vld_o && pc_o == 16'h0,
        "R1", "outputs in reset", {ale_o, ad_oe_o, code_rd_no, byte_vld_o}, 4'b0010);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pc_o == 16'h0 && !ale_o && code_rd_no, "R1", "after reset", pc_o, 0);
  endtask

  task automatic t_idle();
    bit busy = 0;
    logic [15:0] pc0 = pc_o;
    fetch_req_i = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      if (ale_o || ad_oe_o || !code_rd_no || byte_vld_o) busy = 1;
    end
    chk(!busy, "R8", "no activity without request", busy, 0);
    chk(pc_o == pc0, "R8", "pc held while idle", pc_o, pc0);
  endtask

  task automatic t_internal_burst(input int n);
    int_code_i = 1'b1;
    for (int i = 0; i < n; i++) fetch_one(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_external(input int n);
    int_code_i = 1'b0;
    for (int i = 0; i < n; i++) fetch_one(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_strap_mid();
    int_code_i = 1'b0;
    fetch_one(1'b1, 1'b1, 1'b0);   // R9 started external, stays external
    chk(int_code_i == 1'b1, "R9", "strap flipped", int_code_i, 1);
    fetch_one(1'b0, 1'b0, 1'b0);   // R9 next fetch follows new strap
  endtask

  task automatic t_drop_in_vld();
    int_code_i = 1'b0;
    fetch_one(1'b1, 1'b0, 1'b1);   // R8 request dropped in valid cycle
    t_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_internal_burst(3);
    t_external(3);
    t_internal_burst(300);   // crosses 00FFh -> 0100h
    t_external(4);
    t_strap_mid();
    t_drop_in_vld();
    t_external(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule